// File: doc/BRIEF.md
# Global history buffer stride prefetcher

The block watches the stream of cache misses and predicts the next addresses that a load will touch. Every accepted miss is written into a circular history ring of fixed depth, where the newest record replaces the oldest. Each record also holds a back pointer to the previous miss made by the same load instruction. A small tagged table, selected by the load PC, holds the sequence number of that PC's most recent record. The per-PC chains are linked lists threaded through the one shared ring. There is no separate history table per entry.

After it takes a miss, the controller follows the chain back two steps to recover the two previous addresses of that PC, which gives two deltas. When the two deltas are equal and nonzero, it emits `DEGREE` prefetch addresses, one after another, on a valid/ready port: first the miss address plus one delta, then plus two deltas. A pointer counts as live only while the ring slot it names still holds the same sequence number. A pointer to a slot that has since been overwritten ends the chain.

The controller has four states: `ST_IDLE`, `ST_WALK1`, `ST_WALK2` and `ST_ISSUE`.
- `ST_IDLE` to `ST_WALK1`: a miss is accepted. It is written into the ring and into the index table.
- `ST_WALK1` to `ST_WALK2`: the first link is live. Otherwise the controller returns to `ST_IDLE`.
- `ST_WALK2` to `ST_ISSUE`: the second link is live and the two deltas match and are nonzero. Otherwise the controller returns to `ST_IDLE`.
- `ST_ISSUE` to `ST_IDLE`: the last prefetch is accepted.

The `busy` output is high in every state other than `ST_IDLE`, and a miss offered while it is high waits.

Top module: `ghb_prefetcher`

## Requirements
- R1: After reset, `busy` and `pf_valid` are both low.
- R2: A miss is taken in a cycle where `miss_valid` is high and `busy` is low, and `busy` is high in the next cycle. A miss offered while `busy` is high is held, and is taken exactly once after `busy` falls. `pf_valid` is only ever high while `busy` is high.
- R3: When the newest three live misses of a PC are at addresses x2, x1 and x0 (oldest first), with x1-x2 equal to x0-x1 = d and d nonzero, exactly two prefetches follow, in order: x0+d and then x0+2d.
- R4: When the two deltas differ, no prefetch is issued.
- R5: When both deltas are zero, no prefetch is issued.
- R6: A PC with fewer than three live misses on its chain produces no prefetch.
- R7: Misses from other PCs that fall between the misses of one PC do not break that PC's chain, as long as the index slots differ.
- R8: The index slot is PC bits [5:2], and a slot is tagged with the full PC. A miss whose PC finds its slot owned by another PC starts a new chain, so it gets no prefetch.
- R9: The ring holds 32 records. A link to a record that is 32 or more misses older than the current miss is dead and ends the chain. A link to a record exactly 31 misses older is still live.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` does not change.
- R11: Deltas and prefetch addresses are computed modulo 2^32, so negative strides and addresses that wrap below zero are predicted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is offered |
| miss_pc | input | 32 | PC of the load that missed |
| miss_addr | input | 32 | Address of the miss |
| busy | output | 1 | Controller is walking or issuing, so a new miss waits |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | 32 | Prefetch address |

## Verification
The case hardest to reach from the ports is a chain whose link has just aged out of the ring. Reaching it takes a precisely counted run of unrelated misses, exactly one fewer or one more than the ring depth, placed between two misses of a striding PC. The directed part of the stimulus inserts these filler misses from a PC whose deltas are zero, so they issue no prefetches of their own. It also forces a tag conflict in a shared index slot. Randomized traffic from six PCs follows, two of which share an index slot. It mixes strides, jumps, back-to-back stalled misses and random `pf_ready` backpressure, and every prefetch is compared against a reference model of the ring and the index table.

// File: rtl/ghb_pkg.sv
package ghb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK1,
        ST_WALK2,
        ST_ISSUE
    } ghb_state_e;

endpackage

// File: rtl/ghb_ring.sv
module ghb_ring #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEQ_W-1:0]  wr_link,
    input  logic              wr_link_ok,
    input  logic [SEQ_W-1:0]  rd_seq,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SEQ_W-1:0]  rd_link,
    output logic              rd_link_ok
);
    localparam int PTR_W = $clog2(DEPTH);

    logic              slot_used [DEPTH];
    logic [SEQ_W-1:0]  slot_seq  [DEPTH];
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [SEQ_W-1:0]  slot_link [DEPTH];
    logic              slot_lok  [DEPTH];

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign wr_ptr = wr_seq[PTR_W-1:0];
    assign rd_ptr = rd_seq[PTR_W-1:0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_ptr == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_used[g] <= 1'b0;
            end else if (sel) begin
                slot_used[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                slot_seq[g]  <= wr_seq;
                slot_addr[g] <= wr_addr;
                slot_link[g] <= wr_link;
                slot_lok[g]  <= wr_link_ok;
            end
        end
    end

    // A record is still present only if its slot carries the same sequence number.
    assign rd_hit     = slot_used[rd_ptr] && (slot_seq[rd_ptr] == rd_seq);
    assign rd_addr    = slot_addr[rd_ptr];
    assign rd_link    = slot_link[rd_ptr];
    assign rd_link_ok = slot_lok[rd_ptr];

endmodule

// File: rtl/ghb_index.sv
module ghb_index #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int SEQ_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [SEQ_W-1:0] lk_seq,
    input  logic             wr_en,
    input  logic [SEQ_W-1:0] wr_seq
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic             ent_used [ENTRIES];
    logic [PC_W-1:0]  ent_tag  [ENTRIES];
    logic [SEQ_W-1:0] ent_seq  [ENTRIES];

    logic [IDX_W-1:0] idx;
    assign idx = lk_pc[PC_LSB +: IDX_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic sel;
        assign sel = wr_en && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_used[g] <= 1'b0;
            end else if (sel) begin
                ent_used[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                ent_tag[g] <= lk_pc;
                ent_seq[g] <= wr_seq;
            end
        end
    end

    assign lk_hit = ent_used[idx] && (ent_tag[idx] == lk_pc);
    assign lk_seq = ent_seq[idx];

endmodule

// File: rtl/ghb_ctrl.sv
module ghb_ctrl
    import ghb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 16,
    parameter int DEGREE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              idx_hit,
    input  logic [SEQ_W-1:0]  idx_seq,
    output logic              accept,
    output logic [SEQ_W-1:0]  new_seq,
    output logic [SEQ_W-1:0]  rd_seq,
    input  logic              rd_hit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SEQ_W-1:0]  rd_link,
    input  logic              rd_link_ok,
    output logic              busy,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [ADDR_W-1:0] pf_delta
);
    localparam int CNT_W = $clog2(DEGREE + 1);

    ghb_state_e        state_q, state_d;
    logic [SEQ_W-1:0]  seq_q;
    logic [SEQ_W-1:0]  link_q;
    logic              link_ok_q;
    logic [ADDR_W-1:0] a0_q, a1_q;
    logic [ADDR_W-1:0] delta_q;
    logic [ADDR_W-1:0] next_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              chain_ok;
    logic [ADDR_W-1:0] d_near, d_far;
    logic              stride_ok;
    logic              last_pf;

    assign chain_ok  = link_ok_q && rd_hit;
    assign d_near    = a0_q - a1_q;
    assign d_far     = a1_q - rd_addr;
    assign stride_ok = chain_ok && (d_near == d_far) && (d_near != '0);
    assign last_pf   = (cnt_q == CNT_W'(DEGREE));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid) state_d = ST_WALK1;
            ST_WALK1: state_d = chain_ok ? ST_WALK2 : ST_IDLE;
            ST_WALK2: state_d = stride_ok ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: if (pf_ready && last_pf) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        pf_valid = (state_q == ST_ISSUE);
        accept   = (state_q == ST_IDLE) && miss_valid;
        new_seq  = seq_q;
        rd_seq   = link_q;
        pf_addr  = next_q;
        pf_delta = delta_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= '0;
            link_q    <= '0;
            link_ok_q <= 1'b0;
            a0_q      <= '0;
            a1_q      <= '0;
            delta_q   <= '0;
            next_q    <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        a0_q      <= miss_addr;
                        link_q    <= idx_seq;
                        link_ok_q <= idx_hit;
                        seq_q     <= seq_q + 1'b1;
                    end
                end
                ST_WALK1: begin
                    if (chain_ok) begin
                        a1_q      <= rd_addr;
                        link_q    <= rd_link;
                        link_ok_q <= rd_link_ok;
                    end
                end
                ST_WALK2: begin
                    if (stride_ok) begin
                        delta_q <= d_near;
                        next_q  <= a0_q + d_near;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                ST_ISSUE: begin
                    if (pf_ready && !last_pf) begin
                        next_q <= next_q + delta_q;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ghb_prefetcher.sv
module ghb_prefetcher #(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int RING_DEPTH = 32,
    parameter int IDX_DEPTH  = 16,
    parameter int PC_LSB     = 2,
    parameter int SEQ_W      = 16,
    parameter int DEGREE     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              busy,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic              idx_hit;
    logic [SEQ_W-1:0]  idx_seq;
    logic              accept;
    logic [SEQ_W-1:0]  new_seq;
    logic [SEQ_W-1:0]  rd_seq;
    logic              rd_hit;
    logic [ADDR_W-1:0] rd_addr;
    logic [SEQ_W-1:0]  rd_link;
    logic              rd_link_ok;
    logic [ADDR_W-1:0] pf_delta;

    ghb_index #(
        .ENTRIES(IDX_DEPTH), .PC_W(PC_W), .PC_LSB(PC_LSB), .SEQ_W(SEQ_W)
    ) u_index (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(miss_pc), .lk_hit(idx_hit), .lk_seq(idx_seq),
        .wr_en(accept), .wr_seq(new_seq)
    );

    ghb_ring #(
        .DEPTH(RING_DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_seq(new_seq), .wr_addr(miss_addr),
        .wr_link(idx_seq), .wr_link_ok(idx_hit),
        .rd_seq(rd_seq), .rd_hit(rd_hit), .rd_addr(rd_addr),
        .rd_link(rd_link), .rd_link_ok(rd_link_ok)
    );

    ghb_ctrl #(
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DEGREE(DEGREE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .idx_hit(idx_hit), .idx_seq(idx_seq),
        .accept(accept), .new_seq(new_seq), .rd_seq(rd_seq),
        .rd_hit(rd_hit), .rd_addr(rd_addr), .rd_link(rd_link), .rd_link_ok(rd_link_ok),
        .busy(busy), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .pf_delta(pf_delta)
    );

endmodule

// File: rtl/ghb_pf_chk.sv
module ghb_pf_chk #(
    parameter int ADDR_W = 32,
    parameter int DEGREE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              busy,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [ADDR_W-1:0] pf_delta
);
    localparam int HC_W = $clog2(DEGREE + 2);

    logic [HC_W-1:0] hs_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            hs_cnt <= '0;
        end else if (pf_valid && pf_ready) begin
            hs_cnt <= hs_cnt + 1'b1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> busy); // R2

    AST_PF_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> busy); // R2

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (hs_cnt < HC_W'(DEGREE))); // R3

    AST_DELTA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_delta != '0)); // R5

    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R10

endmodule

bind ghb_prefetcher ghb_pf_chk #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .busy(busy),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_delta(pf_delta)
);

// File: tb/tb_ghb_prefetcher.sv
module tb_ghb_prefetcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_pc = '0;
    logic [31:0] miss_addr = '0;
    logic        busy;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;

    always #10 clk = ~clk;

    ghb_prefetcher dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
        .miss_addr(miss_addr), .busy(busy), .pf_valid(pf_valid),
        .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] log_addr [0:2047];
    int          log_link [0:2047];
    int          m_seq = 0;
    bit          m_used [0:15];
    logic [31:0] m_tag  [0:15];
    int          m_iseq [0:15];
    logic [31:0] exp_log [0:4095];
    int          exp_n = 0;

    function automatic bit live(input int cur, input int lnk);
        return (lnk >= 0) && (cur - lnk < 32);
    endfunction

    function automatic int slot_of(input logic [31:0] pc);
        return int'(pc[5:2]);
    endfunction

    task automatic model_accept(input logic [31:0] pc, input logic [31:0] addr);
        int s, ix, l1, l2;
        logic [31:0] a1, a2, d1, d2;
        s  = m_seq;
        ix = slot_of(pc);
        l1 = (m_used[ix] && m_tag[ix] == pc) ? m_iseq[ix] : -1;
        log_addr[s] = addr;
        log_link[s] = l1;
        m_used[ix] = 1'b1;
        m_tag[ix]  = pc;
        m_iseq[ix] = s;
        m_seq++;
        if (live(s, l1)) begin
            a1 = log_addr[l1];
            l2 = log_link[l1];
            if (live(s, l2)) begin
                a2 = log_addr[l2];
                d1 = addr - a1;
                d2 = a1 - a2;
                if (d1 == d2 && d1 != 0) begin
                    for (int k = 1; k <= 2; k++) begin
                        exp_log[exp_n] = addr + d1 * k;
                        exp_n++;
                    end
                end
            end
        end
    endtask

    // ---------------- prefetch collector ----------------
    logic [31:0] hs_log [0:4095];
    int          hs_n = 0;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            pf_ready = ($urandom % 4) != 0;
            if (hold_pend)
                check(pf_valid && pf_addr == hold_addr, "R10 hold under backpressure", pf_addr, hold_addr);
            if (pf_valid && pf_ready) begin
                hs_log[hs_n] = pf_addr;
                hs_n++;
            end
            hold_pend = pf_valid && !pf_ready;
            hold_addr = pf_addr;
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic do_miss(input logic [31:0] pc, input logic [31:0] addr);
        miss_valid = 1'b1;
        miss_pc    = pc;
        miss_addr  = addr;
        while (busy) @(negedge clk);
        model_accept(pc, addr);
        @(negedge clk);
        miss_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
    endtask

    task automatic run_case(input logic [31:0] pc, input logic [31:0] addr, input int exp_cnt,
                            input logic [31:0] e0, input logic [31:0] e1, input string tag);
        int n0;
        drain();
        n0 = hs_n;
        do_miss(pc, addr);
        drain();
        check(hs_n - n0 == exp_cnt, tag, 32'(hs_n - n0), 32'(exp_cnt));
        if (exp_cnt > 0 && hs_n - n0 == exp_cnt) begin
            check(hs_log[n0] == e0, tag, hs_log[n0], e0);
            check(hs_log[n0 + 1] == e1, tag, hs_log[n0 + 1], e1);
        end
    endtask

    localparam logic [31:0] PC_A = 32'h100;  // slot 0
    localparam logic [31:0] PC_B = 32'h204;  // slot 1
    localparam logic [31:0] PC_W = 32'h208;  // slot 2
    localparam logic [31:0] PC_C = 32'h300;  // slot 0, conflicts with PC_A
    localparam logic [31:0] PC_D = 32'h40C;  // slot 3
    localparam logic [31:0] PC_E = 32'h510;  // slot 4
    localparam logic [31:0] PC_F = 32'h614;  // slot 5
    localparam logic [31:0] PC_G = 32'h718;  // slot 6
    localparam logic [31:0] PC_H = 32'h81C;  // slot 7, filler

    task automatic fillers(input int n);
        for (int i = 0; i < n; i++) run_case(PC_H, 32'h5555_0000, 0, 0, 0, "R5 filler zero delta");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rpc [0:5];
        logic [31:0] rcur [0:5];
        logic [31:0] rstr [0:5];
        logic [31:0] strides [0:3];
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin
            m_used[i] = 1'b0; m_tag[i] = '0; m_iseq[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
        check(pf_valid == 1'b0, "R1 pf_valid after reset", 32'(pf_valid), 32'd0);

        run_case(PC_A, 32'h1000, 0, 0, 0, "R6 first miss");
        run_case(PC_A, 32'h1040, 0, 0, 0, "R6 second miss");
        run_case(PC_A, 32'h1080, 2, 32'h10C0, 32'h1100, "R3 equal stride");
        run_case(PC_A, 32'h1100, 0, 0, 0, "R4 deltas differ");
        run_case(PC_A, 32'h1180, 2, 32'h1200, 32'h1280, "R3 stride 0x80");

        run_case(PC_B, 32'h8000, 0, 0, 0, "R6 neg first");
        run_case(PC_B, 32'h7FF0, 0, 0, 0, "R6 neg second");
        run_case(PC_B, 32'h7FE0, 2, 32'h7FD0, 32'h7FC0, "R11 negative stride");
        run_case(PC_W, 32'h10, 0, 0, 0, "R6 wrap first");
        run_case(PC_W, 32'h08, 0, 0, 0, "R6 wrap second");
        run_case(PC_W, 32'h00, 2, 32'hFFFF_FFF8, 32'hFFFF_FFF0, "R11 wrap below zero");

        run_case(PC_D, 32'h500, 0, 0, 0, "R5 zero a");
        run_case(PC_D, 32'h500, 0, 0, 0, "R5 zero b");
        run_case(PC_D, 32'h500, 0, 0, 0, "R5 zero delta");

        run_case(PC_E, 32'h100, 0, 0, 0, "R7 E1");
        run_case(PC_F, 32'h900, 0, 0, 0, "R7 F1");
        run_case(PC_E, 32'h110, 0, 0, 0, "R7 E2");
        run_case(PC_F, 32'h920, 0, 0, 0, "R7 F2");
        run_case(PC_E, 32'h120, 2, 32'h130, 32'h140, "R7 interleaved E");
        run_case(PC_F, 32'h940, 2, 32'h960, 32'h980, "R7 interleaved F");

        run_case(PC_C, 32'h3000, 0, 0, 0, "R8 conflicting PC");
        run_case(PC_A, 32'h1200, 0, 0, 0, "R8 tag lost");
        run_case(PC_A, 32'h1280, 0, 0, 0, "R8 chain of two");
        run_case(PC_A, 32'h1300, 2, 32'h1380, 32'h1400, "R8 chain rebuilt");

        run_case(PC_G, 32'hA000, 0, 0, 0, "R9 G1");
        run_case(PC_G, 32'hA010, 0, 0, 0, "R9 G2");
        run_case(PC_G, 32'hA020, 2, 32'hA030, 32'hA040, "R9 G3");
        fillers(29);
        run_case(PC_G, 32'hA030, 2, 32'hA040, 32'hA050, "R9 link 31 back live");
        fillers(30);
        run_case(PC_G, 32'hA040, 0, 0, 0, "R9 overwritten link");

        // constrained random traffic
        rpc[0] = PC_A; rpc[1] = PC_B; rpc[2] = PC_C;
        rpc[3] = PC_E; rpc[4] = PC_F; rpc[5] = PC_G;
        strides[0] = 32'h40; strides[1] = 32'hFFFF_FFE0;
        strides[2] = 32'h8;  strides[3] = 32'h0;
        for (int i = 0; i < 6; i++) begin
            rcur[i] = 32'h10_0000 * (i + 1);
            rstr[i] = strides[i % 4];
        end
        drain();
        for (int n = 0; n < 400; n++) begin
            int p;
            p = int'($urandom % 6);
            if ($urandom % 10 == 0) rstr[p] = strides[$urandom % 4];
            if ($urandom % 6 == 0) rcur[p] = $urandom;
            else rcur[p] = rcur[p] + rstr[p];
            do_miss(rpc[p], rcur[p]);
            if ($urandom % 2 == 0) drain();
        end
        drain();
        repeat (2) @(negedge clk);

        check(hs_n == exp_n, "R3 total prefetch count vs model", 32'(hs_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < hs_n; i++)
            check(hs_log[i] == exp_log[i], "R3 prefetch address vs model", hs_log[i], exp_log[i]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule